// File: doc/BRIEF.md
# Range Translation Lookaside Buffer

This block is a small, fully associative cache of range translations. Each entry maps a contiguous run of virtual pages of any length onto a contiguous run of physical pages. All pages in the run share one protection setting. A range runs from an inclusive lower virtual page number to an exclusive upper virtual page number. The translation is a signed offset that is added to the virtual page number. Ranges are aligned only to the base page. No power-of-two size or alignment is needed.

The block receives the virtual page number of an access that has already missed in the first-level page TLB. It works alongside the last-level page TLB. All entries test the address in parallel, and the result is registered. One cycle after a lookup, the block returns either a hit or a miss. On a hit it also returns the physical page number and the protection bits, which together form the page-table entry used to refill the first-level TLB. On a miss, the miss flag tells the walker to fetch the range translation from memory, if one exists.

The walker installs entries through a fill port. Two maintenance commands are also provided. One clears every entry. The other clears only the entries whose range covers a given page number.

Top module: `rangeTlb`

## Requirements
- R1: After reset, no entry is valid. While reset is held, respValid, respHit, respMiss, respHitVec, respPpn and respProt are all zero.
- R2: A lookup presented in cycle N produces respValid in cycle N+1. respValid is low in every cycle that follows a cycle without a lookup.
- R3: An entry hits when it is valid and lowerVpn ≤ lookupVpn < upperVpn, compared as unsigned numbers. A page equal to upperVpn does not hit, and neither does a page below lowerVpn.
- R4: On a hit, respPpn is the lookup VPN, zero-extended to PPN_W bits, plus the entry's offset, taken modulo 2^PPN_W. A negative offset is therefore written in two's complement.
- R5: On a hit, respProt equals the protection bits stored in the entry.
- R6: When no valid entry covers the VPN, respMiss is 1 and respHit, respPpn and respProt are 0.
- R7: Bit i of respHitVec is 1 exactly when entry i covers the VPN. When several entries cover it, the lowest-index entry supplies respPpn and respProt.
- R8: A fill whose bounds match no valid entry is written into the lowest-index entry that is not valid.
- R9: When all entries are valid, a fill with new bounds replaces the entry at a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping around, after each such replacement.
- R10: A fill whose lower and upper bounds both equal those of a valid entry overwrites that entry in place.
- R11: flushAll invalidates every entry. In the same cycle, flushAll takes precedence over flushVpnValid and fillValid, and flushVpnValid takes precedence over fillValid. A command that loses to a higher-precedence command is discarded.
- R12: flushVpnValid invalidates every valid entry whose range covers flushVpn and leaves all other entries unchanged.
- R13: A lookup issued in the same cycle as a fill or an invalidation sees the entry contents as they were before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVpn | input | VPN_W | Virtual page number to translate |
| fillValid | input | 1 | Install a range translation |
| fillBase | input | VPN_W | Inclusive lower virtual page of the range |
| fillLimit | input | VPN_W | Exclusive upper virtual page of the range |
| fillOffset | input | PPN_W | Physical start minus lower bound, two's complement |
| fillProt | input | PROT_W | Protection bits of the range |
| flushAll | input | 1 | Invalidate all entries |
| flushVpnValid | input | 1 | Invalidate entries that cover flushVpn |
| flushVpn | input | VPN_W | Page number used for selective invalidation |
| respValid | output | 1 | Response strobe, one cycle after lookupValid |
| respHit | output | 1 | At least one entry covered the VPN |
| respMiss | output | 1 | Response valid and no entry covered the VPN |
| respHitVec | output | ENTRIES | Per-entry match vector |
| respPpn | output | PPN_W | Translated physical page number |
| respProt | output | PROT_W | Protection bits of the winning entry |

## Verification
The hardest state to reach from the ports is a full array, where the round-robin pointer picks the victim. That state only arises after a long run of fills with distinct bounds and no invalidations in between. The stimulus performs exactly as many fills as there are entries, then issues new-bounds fills. The hit vector and a lookup of the evicted range confirm which slot was replaced. Overlapping ranges are built on purpose so that the lowest-index winner can be checked. Two cases cover concurrent commands: a lookup issued together with an invalidation, and commands issued together that must be discarded by precedence. A behavioural model is compared against the design on every clock.

// File: rtl/rtlb_pkg.sv
package rtlb_pkg;
  // Update strobes issued by the control unit to the entry store.
  typedef struct packed {
    logic fill;
    logic flushAll;
    logic flushVpn;
  } rtlbStrobe_t;
endpackage

// File: rtl/rtlb_ctrl.sv
module rtlb_ctrl
  import rtlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  input  logic               flushAllIn,
  input  logic               flushVpnValid,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] sameVec,
  output rtlbStrobe_t        strobe,
  output logic [IDX_W-1:0]   fillIdx
);
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] sameIdx, freeIdx;
  logic             sameFound, freeFound, useVictim;

  // Command precedence: full flush, then selective flush, then fill.
  always_comb begin
    strobe.flushAll = flushAllIn;
    strobe.flushVpn = flushVpnValid & ~flushAllIn;
    strobe.fill     = fillValid & ~flushAllIn & ~flushVpnValid;
  end

  // Lowest-index matching-bounds slot and lowest-index free slot.
  always_comb begin
    sameIdx = '0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (sameVec[i])   sameIdx = IDX_W'(i);
      if (!validVec[i]) freeIdx = IDX_W'(i);
    end
  end

  assign sameFound = |sameVec;
  assign freeFound = ~(&validVec);
  assign fillIdx   = sameFound ? sameIdx : (freeFound ? freeIdx : rrPtr);
  assign useVictim = strobe.fill & ~sameFound & ~freeFound;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (useVictim) begin
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  // R8
  free_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fill && !(&validVec) && !(|sameVec)) |-> !validVec[fillIdx]);

  // R10
  same_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fill && (|sameVec)) |-> sameVec[fillIdx]);

  // R9
  rr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(rrPtr) < ENTRIES);

  // R11
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.fill, strobe.flushAll, strobe.flushVpn}));
endmodule

// File: rtl/rtlb_store.sv
module rtlb_store
  import rtlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 24,
  parameter int PROT_W  = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  rtlbStrobe_t        strobe,
  input  logic [IDX_W-1:0]   fillIdx,
  input  logic [VPN_W-1:0]   fillBase,
  input  logic [VPN_W-1:0]   fillLimit,
  input  logic [PPN_W-1:0]   fillOffset,
  input  logic [PROT_W-1:0]  fillProt,
  input  logic [VPN_W-1:0]   flushVpn,
  input  logic               lookupValid,
  input  logic [VPN_W-1:0]   lookupVpn,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] sameVec,
  output logic               respValid,
  output logic               respHit,
  output logic [ENTRIES-1:0] respHitVec,
  output logic [PPN_W-1:0]   respPpn,
  output logic [PROT_W-1:0]  respProt
);
  logic [VPN_W-1:0]   baseQ   [ENTRIES];
  logic [VPN_W-1:0]   limitQ  [ENTRIES];
  logic [PPN_W-1:0]   offsetQ [ENTRIES];
  logic [PROT_W-1:0]  protQ   [ENTRIES];
  logic [ENTRIES-1:0] hitVec, flushHitVec;
  logic [IDX_W-1:0]   selIdx;
  logic [PPN_W-1:0]   vpnExt;

  // Per-entry bounds comparators for lookup, selective flush and fill merge.
  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    assign hitVec[g]      = validVec[g] && (baseQ[g] <= lookupVpn) && (lookupVpn < limitQ[g]);
    assign flushHitVec[g] = validVec[g] && (baseQ[g] <= flushVpn)  && (flushVpn  < limitQ[g]);
    assign sameVec[g]     = validVec[g] && (baseQ[g] == fillBase)  && (limitQ[g] == fillLimit);
  end

  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) selIdx = IDX_W'(i);
    end
  end

  if (PPN_W >= VPN_W) begin : gExt
    assign vpnExt = {{(PPN_W - VPN_W){1'b0}}, lookupVpn};
  end else begin : gTrunc
    assign vpnExt = lookupVpn[PPN_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
    end else if (strobe.flushAll) begin
      validVec <= '0;
    end else if (strobe.flushVpn) begin
      validVec <= validVec & ~flushHitVec;
    end else if (strobe.fill) begin
      validVec[fillIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      baseQ[fillIdx]   <= fillBase;
      limitQ[fillIdx]  <= fillLimit;
      offsetQ[fillIdx] <= fillOffset;
      protQ[fillIdx]   <= fillProt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respHit    <= 1'b0;
      respHitVec <= '0;
      respPpn    <= '0;
      respProt   <= '0;
    end else begin
      respValid <= lookupValid;
      if (lookupValid && (|hitVec)) begin
        respHit    <= 1'b1;
        respHitVec <= hitVec;
        respPpn    <= vpnExt + offsetQ[selIdx];
        respProt   <= protQ[selIdx];
      end else begin
        respHit    <= 1'b0;
        respHitVec <= '0;
        respPpn    <= '0;
        respProt   <= '0;
      end
    end
  end

  // R2
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);

  // R11
  flush_all_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushAll |=> (validVec == '0));

  // R12
  flush_vpn_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushVpn |=> ((validVec & $past(flushHitVec)) == '0));

  // R8
  fill_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |=> validVec[$past(fillIdx)]);
endmodule

// File: rtl/rangeTlb.sv
module rangeTlb
  import rtlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 24,
  parameter int PROT_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic [VPN_W-1:0]   lookupVpn,
  input  logic               fillValid,
  input  logic [VPN_W-1:0]   fillBase,
  input  logic [VPN_W-1:0]   fillLimit,
  input  logic [PPN_W-1:0]   fillOffset,
  input  logic [PROT_W-1:0]  fillProt,
  input  logic               flushAll,
  input  logic               flushVpnValid,
  input  logic [VPN_W-1:0]   flushVpn,
  output logic               respValid,
  output logic               respHit,
  output logic               respMiss,
  output logic [ENTRIES-1:0] respHitVec,
  output logic [PPN_W-1:0]   respPpn,
  output logic [PROT_W-1:0]  respProt
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  rtlbStrobe_t        strobe;
  logic [IDX_W-1:0]   fillIdx;
  logic [ENTRIES-1:0] validVec, sameVec;

  rtlb_ctrl #(.ENTRIES(ENTRIES)) i_ctrl (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .flushAllIn(flushAll),
    .flushVpnValid(flushVpnValid), .validVec(validVec), .sameVec(sameVec),
    .strobe(strobe), .fillIdx(fillIdx)
  );

  rtlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PROT_W(PROT_W)) i_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fillIdx(fillIdx),
    .fillBase(fillBase), .fillLimit(fillLimit), .fillOffset(fillOffset),
    .fillProt(fillProt), .flushVpn(flushVpn), .lookupValid(lookupValid),
    .lookupVpn(lookupVpn), .validVec(validVec), .sameVec(sameVec),
    .respValid(respValid), .respHit(respHit), .respHitVec(respHitVec),
    .respPpn(respPpn), .respProt(respProt)
  );

  assign respMiss = respValid & ~respHit;

  // R6
  miss_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    respMiss |-> (respHitVec == '0 && respPpn == '0));
endmodule

// File: tb/test_rangeTlb.sv
module test_rangeTlb;
  localparam int E = 32;
  localparam int VW = 20;
  localparam int PW = 24;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [VW-1:0] lookupVpn = '0;
  logic fillValid = 1'b0;
  logic [VW-1:0] fillBase = '0, fillLimit = '0;
  logic [PW-1:0] fillOffset = '0;
  logic [RW-1:0] fillProt = '0;
  logic flushAll = 1'b0, flushVpnValid = 1'b0;
  logic [VW-1:0] flushVpn = '0;
  logic respValid, respHit, respMiss;
  logic [E-1:0] respHitVec;
  logic [PW-1:0] respPpn;
  logic [RW-1:0] respProt;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rangeTlb i_rangeTlb (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .fillValid(fillValid), .fillBase(fillBase), .fillLimit(fillLimit),
    .fillOffset(fillOffset), .fillProt(fillProt), .flushAll(flushAll),
    .flushVpnValid(flushVpnValid), .flushVpn(flushVpn), .respValid(respValid),
    .respHit(respHit), .respMiss(respMiss), .respHitVec(respHitVec),
    .respPpn(respPpn), .respProt(respProt)
  );

  // Behavioural reference model
  logic [VW-1:0] mB [E];
  logic [VW-1:0] mL [E];
  logic [PW-1:0] mO [E];
  logic [RW-1:0] mP [E];
  bit mV [E];
  int mRr = 0;
  logic eValid = 0, eHit = 0;
  logic [E-1:0] eVec = '0;
  logic [PW-1:0] ePpn = '0;
  logic [RW-1:0] eProt = '0;

  function automatic bit covers(int i, logic [VW-1:0] v);
    return mV[i] && (mB[i] <= v) && (v < mL[i]);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < E; i++) mV[i] = 0;
      mRr = 0;
      eValid = 0; eHit = 0; eVec = '0; ePpn = '0; eProt = '0;
    end else begin
      int win;
      win = -1;
      eVec = '0;
      for (int i = E - 1; i >= 0; i--)
        if (lookupValid && covers(i, lookupVpn)) begin eVec[i] = 1'b1; win = i; end
      eValid = lookupValid;
      eHit = (win >= 0);
      ePpn = eHit ? PW'(lookupVpn) + mO[win] : '0;
      eProt = eHit ? mP[win] : '0;
      if (flushAll) begin
        for (int i = 0; i < E; i++) mV[i] = 0;
      end else if (flushVpnValid) begin
        bit kill [E];
        for (int i = 0; i < E; i++) kill[i] = covers(i, flushVpn);
        for (int i = 0; i < E; i++) if (kill[i]) mV[i] = 0;
      end else if (fillValid) begin
        int slot;
        slot = -1;
        for (int i = E - 1; i >= 0; i--)
          if (mV[i] && mB[i] == fillBase && mL[i] == fillLimit) slot = i;
        if (slot < 0)
          for (int i = E - 1; i >= 0; i--) if (!mV[i]) slot = i;
        if (slot < 0) begin slot = mRr; mRr = (mRr + 1) % E; end
        mV[slot] = 1; mB[slot] = fillBase; mL[slot] = fillLimit;
        mO[slot] = fillOffset; mP[slot] = fillProt;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Model comparison on every clock
  always @(negedge clk) begin
    if (!finished) begin
      chk(respValid == eValid, curReq, "model respValid", 64'(respValid), 64'(eValid));
      chk(respHit == eHit, curReq, "model respHit", 64'(respHit), 64'(eHit));
      chk(respMiss == (eValid & ~eHit), curReq, "model respMiss", 64'(respMiss), 64'(eValid & ~eHit));
      chk(respHitVec == eVec, curReq, "model respHitVec", 64'(respHitVec), 64'(eVec));
      chk(respPpn == ePpn, curReq, "model respPpn", 64'(respPpn), 64'(ePpn));
      chk(respProt == eProt, curReq, "model respProt", 64'(respProt), 64'(eProt));
    end
  end

  task automatic doFill(logic [VW-1:0] b, logic [VW-1:0] l, logic [PW-1:0] o, logic [RW-1:0] p);
    @(negedge clk);
    fillValid = 1; fillBase = b; fillLimit = l; fillOffset = o; fillProt = p;
    @(negedge clk);
    fillValid = 0;
  endtask

  task automatic look(logic [VW-1:0] v, string req, bit hit, logic [E-1:0] vec,
                      logic [PW-1:0] ppn, logic [RW-1:0] prot);
    @(negedge clk);
    lookupValid = 1; lookupVpn = v;
    @(negedge clk);
    chk(respValid == 1'b1, req, "respValid", 64'(respValid), 64'd1);
    chk(respHit == hit, req, "respHit", 64'(respHit), 64'(hit));
    chk(respMiss == !hit, req, "respMiss", 64'(respMiss), 64'(!hit));
    chk(respHitVec == vec, req, "respHitVec", 64'(respHitVec), 64'(vec));
    chk(respPpn == ppn, req, "respPpn", 64'(respPpn), 64'(ppn));
    chk(respProt == prot, req, "respProt", 64'(respProt), 64'(prot));
    lookupValid = 0;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    curReq = "R1";
    repeat (3) @(negedge clk);
    chk(respValid == 0 && respHit == 0 && respMiss == 0, "R1", "reset flags", 64'(respValid), 64'd0);
    chk(respHitVec == '0 && respPpn == '0 && respProt == '0, "R1", "reset data", 64'(respPpn), 64'd0);
    rstN = 1;
    look(20'h5, "R1", 0, '0, '0, '0);
    curReq = "R2";
    @(negedge clk);
    @(negedge clk);
    chk(respValid == 0, "R2", "no lookup no response", 64'(respValid), 64'd0);

    curReq = "R3";
    doFill(20'h100, 20'h180, 24'h5000, 4'h3);
    look(20'h100, "R3", 1, 32'h1, 24'h5100, 4'h3);
    look(20'h17F, "R4", 1, 32'h1, 24'h517F, 4'h3);
    look(20'h180, "R3", 0, '0, '0, '0);
    look(20'h0FF, "R6", 0, '0, '0, '0);

    curReq = "R4";
    doFill(20'h200, 20'h203, 24'hFFFF00, 4'h5);
    look(20'h201, "R4", 1, 32'h2, 24'h000101, 4'h5);

    curReq = "R7";
    doFill(20'h150, 20'h250, 24'h10, 4'hA);
    look(20'h160, "R7", 1, 32'h5, 24'h5160, 4'h3);
    look(20'h202, "R7", 1, 32'h6, 24'h102, 4'h5);

    curReq = "R10";
    doFill(20'h200, 20'h203, 24'h40, 4'h6);
    look(20'h202, "R10", 1, 32'h6, 24'h242, 4'h6);
    look(20'h210, "R5", 1, 32'h4, 24'h220, 4'hA);

    curReq = "R12";
    @(negedge clk); flushVpnValid = 1; flushVpn = 20'h170;
    @(negedge clk); flushVpnValid = 0;
    look(20'h170, "R12", 0, '0, '0, '0);
    look(20'h201, "R12", 1, 32'h2, 24'h241, 4'h6);

    curReq = "R8";
    doFill(20'h400, 20'h410, 24'h0, 4'h1);
    look(20'h405, "R8", 1, 32'h1, 24'h405, 4'h1);

    curReq = "R13";
    @(negedge clk);
    flushAll = 1; fillValid = 1; fillBase = 20'h600; fillLimit = 20'h601;
    lookupValid = 1; lookupVpn = 20'h405;
    @(negedge clk);
    flushAll = 0; fillValid = 0; lookupValid = 0;
    chk(respHit == 1 && respPpn == 24'h405, "R13", "lookup sees old state", 64'(respPpn), 64'h405);
    curReq = "R11";
    look(20'h405, "R11", 0, '0, '0, '0);
    look(20'h600, "R11", 0, '0, '0, '0);

    curReq = "R9";
    for (int i = 0; i < E; i++)
      doFill(VW'(20'h1000 + i * 16), VW'(20'h1010 + i * 16), PW'(i << 12), RW'(i));
    look(20'h1003, "R9", 1, 32'h1, 24'h001003, 4'h0);
    doFill(20'h3000, 20'h3001, 24'h7, 4'h9);
    look(20'h3000, "R9", 1, 32'h1, 24'h3007, 4'h9);
    look(20'h1005, "R9", 0, '0, '0, '0);
    doFill(20'h3100, 20'h3101, 24'h8, 4'h2);
    look(20'h3100, "R9", 1, 32'h2, 24'h3108, 4'h2);

    curReq = "R11";
    @(negedge clk);
    flushVpnValid = 1; flushVpn = 20'h3000;
    fillValid = 1; fillBase = 20'h3200; fillLimit = 20'h3201; fillOffset = 24'h1; fillProt = 4'h1;
    @(negedge clk);
    flushVpnValid = 0; fillValid = 0;
    look(20'h3200, "R11", 0, '0, '0, '0);
    look(20'h3000, "R12", 0, '0, '0, '0);
    curReq = "R8";
    doFill(20'h3300, 20'h3302, 24'h2, 4'h4);
    look(20'h3301, "R8", 1, 32'h1, 24'h3303, 4'h4);

    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule